// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the control address register of a microprogrammed control unit and works out, every clock, which word of a 128-word control memory is read next. Four sources compete for the register: the current address plus one, a branch target carried in the microinstruction, an entry point derived from a 4-bit machine opcode, and a return address kept in a one-deep subroutine register. The control memory sits outside the block. Its output supplies the condition-select, branch-type and branch-address fields. The rest of the machine supplies the opcode and the status bits.

A conditional step picks one status bit through a multiplexer. If that bit is 1, the step jumps or calls. If it is 0, the sequence falls through to the next word. Each opcode maps to its own 4-word slot in the lower half of control memory. A routine ends with a jump to address 0, which is where the fetch routine starts. Such a jump is made unconditional by selecting a status bit that is tied high.

Top module: `mseq_top`

## Requirements
- R1: A synchronous active-high reset clears the control address and the subroutine register to 0. A return issued right after reset therefore goes to address 0.
- R2: The condition used by a conditional step is bit number `cond_sel_i` of `status_i`. A value of 1 means taken.
- R3: Branch type 2'b00 (jump): when the condition is taken, the next control address is `baddr_i`.
- R4: For a jump or a call whose condition is not taken, the next control address is the current address plus one, modulo 128. Address 127 is followed by address 0.
- R5: Branch type 2'b01 (call): when the condition is taken, the next control address is `baddr_i` and the subroutine register captures the current address plus one, modulo 128. A call that is not taken leaves the subroutine register unchanged.
- R6: Branch type 2'b10 (return) loads the control address from the subroutine register whatever the condition.
- R7: Branch type 2'b11 (map) loads, whatever the condition, the address whose bit 6 is 0, whose bits 5:2 are `opcode_i` and whose bits 1:0 are 0. For opcode 4'hA this is 7'h28.
- R8: `sbr_we_o` is 1 in a cycle exactly when that cycle holds a taken call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cond_sel_i | input | 3 | Index of the status bit to test |
| btype_i | input | 2 | Branch type: 00 jump, 01 call, 10 return, 11 map |
| baddr_i | input | 7 | Branch or call target from the microinstruction |
| opcode_i | input | 4 | Machine opcode used by the map step |
| status_i | input | 8 | Status bits offered to the condition multiplexer |
| car_o | output | 7 | Control address register, read address of control memory |
| sbr_we_o | output | 1 | Write enable of the subroutine register |

## Verification
The control address changes one clock edge after the fields that select it are applied. The bench drives the fields on a falling edge and reads `car_o` on the following falling edge, so each read falls after exactly one rising edge. `sbr_we_o` is combinational in the current fields, so it is read a nanosecond after they are driven and before the next rising edge. A captured return address cannot be seen directly. It is read one step later by issuing a return and observing `car_o`, which shows both writes and missed writes of the subroutine register.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
package mseq_pkg;

    localparam int CAR_W  = 7;
    localparam int OPC_W  = 4;
    localparam int SLOT_W = 2;
    localparam int NSTAT  = 8;
    localparam int CSEL_W = $clog2(NSTAT);

    typedef enum logic [1:0] {
        BT_JUMP = 2'b00,
        BT_CALL = 2'b01,
        BT_RET  = 2'b10,
        BT_MAP  = 2'b11
    } btype_e;

    typedef enum logic [1:0] {
        SRC_INC,
        SRC_BRANCH,
        SRC_MAP,
        SRC_SUB
    } src_e;

    typedef struct packed {
        src_e src;
        logic save;
    } step_t;

    // Jump and call depend on the selected status bit; return and map do not.
    function automatic logic is_conditional(input btype_e bt);
        return (bt == BT_JUMP) || (bt == BT_CALL);
    endfunction

endpackage

// File: rtl/mseq_cond_sel.sv
`timescale 1ns/1ps
module mseq_cond_sel #(
    parameter int NSTAT  = 8,
    parameter int CSEL_W = $clog2(NSTAT)
) (
    input  logic [NSTAT-1:0]  status_i,
    input  logic [CSEL_W-1:0] sel_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = status_i[sel_i];
    end
endmodule

// File: rtl/mseq_decode.sv
`timescale 1ns/1ps
module mseq_decode
    import mseq_pkg::*;
(
    input  logic [1:0] btype_i,
    input  logic       hit_i,
    output step_t      step_o
);
    btype_e bt;

    always_comb begin
        bt          = btype_e'(btype_i);
        step_o.src  = SRC_INC;
        step_o.save = 1'b0;
        if (is_conditional(bt) && !hit_i) begin
            step_o.src = SRC_INC;
        end else begin
            unique case (bt)
                BT_JUMP: step_o.src = SRC_BRANCH;
                BT_CALL: begin
                    step_o.src  = SRC_BRANCH;
                    step_o.save = 1'b1;
                end
                BT_RET:  step_o.src = SRC_SUB;
                BT_MAP:  step_o.src = SRC_MAP;
                default: step_o.src = SRC_INC;
            endcase
        end
    end
endmodule

// File: rtl/mseq_subreg.sv
`timescale 1ns/1ps
module mseq_subreg #(
    parameter int CAR_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             we_i,
    input  logic [CAR_W-1:0] d_i,
    output logic [CAR_W-1:0] q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)
            q_o <= '0;
        else if (we_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/mseq_next.sv
`timescale 1ns/1ps
module mseq_next
    import mseq_pkg::*;
#(
    parameter int CAR_W  = 7,
    parameter int OPC_W  = 4,
    parameter int SLOT_W = 2
) (
    input  logic [CAR_W-1:0] car_i,
    input  logic [CAR_W-1:0] baddr_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [CAR_W-1:0] sub_i,
    input  src_e             src_i,
    output logic [CAR_W-1:0] inc_o,
    output logic [CAR_W-1:0] next_o
);
    logic [CAR_W-1:0] mapped;

    always_comb begin
        inc_o  = car_i + 1'b1;
        mapped = CAR_W'(opcode_i) << SLOT_W;
        unique case (src_i)
            SRC_BRANCH: next_o = baddr_i;
            SRC_MAP:    next_o = mapped;
            SRC_SUB:    next_o = sub_i;
            default:    next_o = inc_o;
        endcase
    end
endmodule

// File: rtl/mseq_top.sv
`timescale 1ns/1ps
module mseq_top
    import mseq_pkg::*;
#(
    parameter int CAR_W  = mseq_pkg::CAR_W,
    parameter int OPC_W  = mseq_pkg::OPC_W,
    parameter int SLOT_W = mseq_pkg::SLOT_W,
    parameter int NSTAT  = mseq_pkg::NSTAT,
    parameter int CSEL_W = $clog2(NSTAT)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CSEL_W-1:0] cond_sel_i,
    input  logic [1:0]        btype_i,
    input  logic [CAR_W-1:0]  baddr_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [NSTAT-1:0]  status_i,
    output logic [CAR_W-1:0]  car_o,
    output logic              sbr_we_o
);
    logic             hit;
    step_t            step;
    logic [CAR_W-1:0] car_q;
    logic [CAR_W-1:0] sbr_q;
    logic [CAR_W-1:0] car_inc;
    logic [CAR_W-1:0] car_nxt;

    mseq_cond_sel #(.NSTAT(NSTAT), .CSEL_W(CSEL_W)) u_cond (
        .status_i (status_i),
        .sel_i    (cond_sel_i),
        .hit_o    (hit)
    );

    mseq_decode u_dec (
        .btype_i (btype_i),
        .hit_i   (hit),
        .step_o  (step)
    );

    mseq_next #(.CAR_W(CAR_W), .OPC_W(OPC_W), .SLOT_W(SLOT_W)) u_next (
        .car_i    (car_q),
        .baddr_i  (baddr_i),
        .opcode_i (opcode_i),
        .sub_i    (sbr_q),
        .src_i    (step.src),
        .inc_o    (car_inc),
        .next_o   (car_nxt)
    );

    mseq_subreg #(.CAR_W(CAR_W)) u_sbr (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .we_i  (step.save),
        .d_i   (car_inc),
        .q_o   (sbr_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)
            car_q <= '0;
        else
            car_q <= car_nxt;
    end

    assign car_o    = car_q;
    assign sbr_we_o = step.save;

endmodule

// File: rtl/mseq_top_chk.sv
`timescale 1ns/1ps
module mseq_top_chk #(
    parameter int CAR_W  = 7,
    parameter int OPC_W  = 4,
    parameter int SLOT_W = 2,
    parameter int NSTAT  = 8,
    parameter int CSEL_W = $clog2(NSTAT)
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [CSEL_W-1:0] cond_sel_i,
    input logic [1:0]        btype_i,
    input logic [CAR_W-1:0]  baddr_i,
    input logic [OPC_W-1:0]  opcode_i,
    input logic [NSTAT-1:0]  status_i,
    input logic [CAR_W-1:0]  car_o,
    input logic              sbr_we_o,
    input logic [CAR_W-1:0]  sbr_q
);
    logic [CAR_W-1:0] car_plus;
    logic [CAR_W-1:0] map_exp;
    logic             cond;

    always_comb begin
        car_plus = car_o + 1'b1;
        map_exp  = CAR_W'(opcode_i) << SLOT_W;
        cond     = status_i[cond_sel_i];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (car_o == '0 && sbr_q == '0));

    // R3
    jump_taken_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (btype_i == 2'b00 && cond) |=> car_o == $past(baddr_i));

    // R4
    fall_through_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (btype_i[1] == 1'b0 && !cond) |=> car_o == $past(car_plus));

    // R5
    call_save_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (btype_i == 2'b01 && cond) |=> sbr_q == $past(car_plus));

    // R6
    return_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (btype_i == 2'b10) |=> car_o == $past(sbr_q));

    // R7
    map_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (btype_i == 2'b11) |=> car_o == $past(map_exp));

    // R8
    save_only_on_call_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sbr_we_o |-> (btype_i == 2'b01 && cond));

    // R5
    sbr_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !sbr_we_o |=> $stable(sbr_q));

endmodule

bind mseq_top mseq_top_chk #(
    .CAR_W(CAR_W), .OPC_W(OPC_W), .SLOT_W(SLOT_W), .NSTAT(NSTAT), .CSEL_W(CSEL_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cond_sel_i (cond_sel_i),
    .btype_i    (btype_i),
    .baddr_i    (baddr_i),
    .opcode_i   (opcode_i),
    .status_i   (status_i),
    .car_o      (car_o),
    .sbr_we_o   (sbr_we_o),
    .sbr_q      (sbr_q)
);

// File: tb/mseq_top_test.sv
`timescale 1ns/1ps
module mseq_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cond_sel = '0;
    logic [1:0] btype = '0;
    logic [6:0] baddr = '0;
    logic [3:0] opcode = '0;
    logic [7:0] status = '0;
    logic [6:0] car;
    logic       sbr_we;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mseq_top uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .cond_sel_i (cond_sel),
        .btype_i    (btype),
        .baddr_i    (baddr),
        .opcode_i   (opcode),
        .status_i   (status),
        .car_o      (car),
        .sbr_we_o   (sbr_we)
    );

    // vector: sel(3) btype(2) baddr(7) opcode(4) status(8) exp_car(7) exp_we(1)
    localparam int NV = 16;
    localparam logic [31:0] VEC [NV] = '{
        {3'd0, 2'b00, 7'h15, 4'h0, 8'h01, 7'h15, 1'b0}, // R3 R2 taken jump
        {3'd1, 2'b00, 7'h40, 4'h0, 8'h01, 7'h16, 1'b0}, // R4 R2 untaken jump
        {3'd2, 2'b01, 7'h50, 4'h0, 8'h04, 7'h50, 1'b1}, // R5 call, save 17
        {3'd0, 2'b00, 7'h7F, 4'h0, 8'h00, 7'h51, 1'b0}, // R4
        {3'd0, 2'b10, 7'h00, 4'h0, 8'h00, 7'h17, 1'b0}, // R6 return
        {3'd3, 2'b11, 7'h00, 4'hA, 8'h00, 7'h28, 1'b0}, // R7 map
        {3'd3, 2'b01, 7'h10, 4'h0, 8'h00, 7'h29, 1'b0}, // R5 untaken call
        {3'd0, 2'b10, 7'h00, 4'h0, 8'h00, 7'h17, 1'b0}, // R6 sbr kept
        {3'd0, 2'b11, 7'h00, 4'hF, 8'h00, 7'h3C, 1'b0}, // R7
        {3'd0, 2'b11, 7'h00, 4'h0, 8'h00, 7'h00, 1'b0}, // R7
        {3'd7, 2'b00, 7'h7F, 4'h0, 8'h80, 7'h7F, 1'b0}, // R3 R2 top bit
        {3'd0, 2'b00, 7'h00, 4'h0, 8'h00, 7'h00, 1'b0}, // R4 wrap
        {3'd7, 2'b01, 7'h7E, 4'h0, 8'h80, 7'h7E, 1'b1}, // R5 save 01
        {3'd6, 2'b00, 7'h00, 4'h0, 8'h80, 7'h7F, 1'b0}, // R4
        {3'd7, 2'b01, 7'h20, 4'h0, 8'h80, 7'h20, 1'b1}, // R5 save wraps to 00
        {3'd0, 2'b10, 7'h55, 4'h0, 8'hFF, 7'h00, 1'b0}  // R6
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] s, input logic [1:0] b, input logic [6:0] a,
                         input logic [3:0] o, input logic [7:0] st);
        cond_sel = s; btype = b; baddr = a; opcode = o; status = st;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick();
        tick();
        check("R1 reset address", car, 7'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][31:29], VEC[i][28:27], VEC[i][26:20], VEC[i][19:16], VEC[i][15:8]);
            #1;
            check($sformatf("R8 write enable vec %0d", i), sbr_we, VEC[i][0]);
            tick();
            check($sformatf("R3-R7 next address vec %0d", i), car, VEC[i][7:1]);
        end

        // R7: every opcode lands in its own 4-word slot below 64
        for (int op = 0; op < 16; op++) begin
            drive(3'd0, 2'b11, 7'h7F, op[3:0], 8'hFF);
            tick();
            check($sformatf("R7 map opcode %0d", op), car, {1'b0, op[3:0], 2'b00});
        end

        // R1: reset also clears the subroutine register
        drive(3'd7, 2'b01, 7'h30, 4'h0, 8'h80);
        tick();
        check("R5 call before reset", car, 7'h30);
        drive(3'd7, 2'b00, 7'h33, 4'h0, 8'h80);
        tick();
        check("R3 jump before reset", car, 7'h33);
        rst = 1'b1;
        tick();
        check("R1 reset mid-run", car, 7'h00);
        rst = 1'b0;
        drive(3'd0, 2'b10, 7'h00, 4'h0, 8'h00);
        tick();
        check("R1 return after reset", car, 7'h00);

        // R2: untaken call with the selected bit low while others are high
        drive(3'd4, 2'b01, 7'h44, 4'h0, 8'hEF);
        #1;
        check("R2 R8 no write on low bit", sbr_we, 1'b0);
        tick();
        check("R2 R4 untaken call", car, 7'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule